// File: doc/BRIEF.md
# Pseudo-Static RAM Power Mode Sequencer

This block sits on the host side of a pseudo-static RAM and owns three of its control pins: the active-low sleep pin, chip select and write strobe. It handles three host requests, each a one-cycle pulse. It loads the memory's refresh configuration word by running a write cycle while the sleep pin is held low. It takes the memory into deep power down in two steps. It brings the memory back out, enforcing the minimum dwell in the low-power state and the recovery wait after leaving it.

Every delay is given in nanoseconds and turned into clock cycles from the clock period parameter. A request is either accepted or refused. A refused request gives a one-cycle error pulse and is dropped, not queued. The host watches `ready` to learn when the memory can take normal traffic.

Top module: `psram_pwr_seq`

## Requirements
- R1: From reset, chip select, write strobe and the sleep pin are all held high (inactive) and `ready` stays low for at least the power-up time T_PWRUP_NS. After that time `ready` rises.
- R2: A configuration write first drives the sleep pin low. At least 10 ns and at most 500 ns later, chip select and write strobe fall together. They stay low for at least T_WR_PULSE_NS. The sleep pin stays low for as long as the strobe is low.
- R3: During a configuration write, the address bus carries the requested word with bits 20 to 8 and bit 3 forced to zero. Bits 7 to 4 and 2 to 0 pass through unchanged.
- R4: When a configuration write ends, the strobe, chip select and sleep pin all return high together. They stay high for at least one cycle and at least T_GAP_NS before the sleep pin falls again.
- R5: An enter request is refused with an error pulse, and the sleep pin stays high, unless the last configuration word written had bit 4 = 0 (armed). After reset no word has been written, so the block counts as disarmed.
- R6: An accepted enter request first holds the sleep pin high with chip select high for at least T_GAP_NS. It then drives the sleep pin low with chip select high, for longer than T_ZZ_HOLD_NS before the memory counts as powered down.
- R7: An exit request that arrives before the minimum dwell is kept pending. The sleep pin is released only after it has been low for more than T_ZZ_HOLD_NS + T_DPD_MIN_NS. An exit request that arrives after the minimum dwell releases the sleep pin within one cycle.
- R8: After the sleep pin rises at exit, chip select stays high and `ready` stays low for at least T_RECOV_NS. Then `ready` rises.
- R9: A request that the current state cannot accept produces a one-cycle `err` pulse on the cycle after the request and has no later effect. This covers any request while busy, and an exit request while idle.
- R10: `ready` is high only when idle. `busy` is high whenever the block is neither idle nor powered down without a pending exit. The two are never high together.
- R11: The arm state is kept through power down and recovery, so a second enter request with no new configuration write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (models power application) |
| req_cfg | input | 1 | Pulse: write `cfg_word` to the configuration register |
| cfg_word | input | 21 | Configuration word, sampled with `req_cfg` |
| req_dpd_enter | input | 1 | Pulse: enter deep power down |
| req_dpd_exit | input | 1 | Pulse: leave deep power down |
| busy | output | 1 | A sequence is in progress |
| ready | output | 1 | Memory is idle and available for normal access |
| err | output | 1 | One-cycle pulse: the previous request was refused |
| mem_zz_n | output | 1 | Sleep pin to memory, active low |
| mem_cs_n | output | 1 | Chip select to memory, active low |
| mem_we_n | output | 1 | Write strobe to memory, active low |
| mem_addr | output | 21 | Address bus carrying the configuration word |

## Verification
The bench builds the block with a 4 ns clock and scaled-down delays. Power-up and recovery are 400 ns, the hold is 200 ns, the minimum dwell is 2000 ns and the write pulse is 40 ns. The lead time and gap keep their real values of 10 ns and 5 ns. With these values a full power-down and exit cycle takes about 650 clock cycles. That makes it possible to exercise both early and late exit requests, back-to-back configuration and power-down, and refusals during every phase. The scaled delays still give the 500-cycle dwell and 100-cycle recovery exact cycle counts at the pins.

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq #(
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_PWRUP_NS    = 150000,
  parameter int T_ZZ_LEAD_NS  = 10,
  parameter int T_WR_PULSE_NS = 50,
  parameter int T_GAP_NS      = 5,
  parameter int T_ZZ_HOLD_NS  = 10000,
  parameter int T_DPD_MIN_NS  = 1000000,
  parameter int T_RECOV_NS    = 150000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_cfg,
  input  logic [20:0] cfg_word,
  input  logic        req_dpd_enter,
  input  logic        req_dpd_exit,
  output logic        busy,
  output logic        ready,
  output logic        err,
  output logic        mem_zz_n,
  output logic        mem_cs_n,
  output logic        mem_we_n,
  output logic [20:0] mem_addr
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int N_PWR  = cyc(T_PWRUP_NS);
  localparam int N_LEAD = cyc(T_ZZ_LEAD_NS);
  localparam int N_WP   = cyc(T_WR_PULSE_NS);
  localparam int N_GAP  = cyc(T_GAP_NS);
  localparam int N_HOLD = T_ZZ_HOLD_NS / CLK_PERIOD_NS + 1;
  localparam int N_MIN  = cyc(T_DPD_MIN_NS);
  localparam int N_REC  = cyc(T_RECOV_NS);
  localparam int N_M1   = (N_PWR > N_MIN) ? N_PWR : N_MIN;
  localparam int N_M2   = (N_REC > N_HOLD) ? N_REC : N_HOLD;
  localparam int N_MAX  = (N_M1 > N_M2) ? N_M1 : N_M2;
  localparam int TW     = $clog2(N_MAX + 1);
  localparam logic [20:0] KEEP = 21'h0000F7;

  typedef enum logic [3:0] {
    S_PWRUP, S_IDLE, S_CFG_ZZ, S_CFG_WR, S_CFG_END,
    S_GAP, S_HOLD, S_DPD, S_RECOV
  } st_t;

  st_t st, nxt;
  logic [TW-1:0] tmr, nload;
  logic armed, pend;
  logic tdone;

  assign tdone = (tmr == '0);

  always_comb begin
    nxt   = st;
    nload = '0;
    case (st)
      S_PWRUP:   if (tdone) nxt = S_IDLE;
      S_IDLE:
        if (req_cfg) begin
          nxt = S_CFG_ZZ; nload = TW'(N_LEAD - 1);
        end else if (req_dpd_enter && armed) begin
          nxt = S_GAP; nload = TW'(N_GAP - 1);
        end
      S_CFG_ZZ:  if (tdone) begin nxt = S_CFG_WR;  nload = TW'(N_WP - 1);   end
      S_CFG_WR:  if (tdone) begin nxt = S_CFG_END; nload = TW'(N_GAP - 1);  end
      S_CFG_END: if (tdone) nxt = S_IDLE;
      S_GAP:     if (tdone) begin nxt = S_HOLD;    nload = TW'(N_HOLD - 1); end
      S_HOLD:    if (tdone) begin nxt = S_DPD;     nload = TW'(N_MIN - 1);  end
      S_DPD:
        if (tdone && (pend || req_dpd_exit)) begin
          nxt = S_RECOV; nload = TW'(N_REC - 1);
        end
      S_RECOV:   if (tdone) nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_PWRUP;
      tmr      <= TW'(N_PWR - 1);
      armed    <= 1'b0;
      pend     <= 1'b0;
      err      <= 1'b0;
      mem_addr <= '0;
    end else begin
      st <= nxt;
      if (st != nxt)   tmr <= nload;
      else if (!tdone) tmr <= tmr - 1'b1;
      pend <= (st == S_DPD) && (nxt == S_DPD) && (pend || req_dpd_exit);
      if (st == S_IDLE && req_cfg) begin
        mem_addr <= cfg_word & KEEP;
        armed    <= ~cfg_word[4];
      end
      err <= (req_cfg && st != S_IDLE)
           | (req_dpd_enter && !(st == S_IDLE && !req_cfg && armed))
           | (req_dpd_exit && st != S_DPD);
    end
  end

  assign mem_zz_n = !(st == S_CFG_ZZ || st == S_CFG_WR || st == S_HOLD || st == S_DPD);
  assign mem_cs_n = (st != S_CFG_WR);
  assign mem_we_n = (st != S_CFG_WR);
  assign ready    = (st == S_IDLE);
  assign busy     = !(ready || (st == S_DPD && !pend));

endmodule

// File: rtl/psram_pwr_seq_chk.sv
module psram_pwr_seq_chk #(
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_ZZ_HOLD_NS  = 10000,
  parameter int T_DPD_MIN_NS  = 1000000,
  parameter int T_RECOV_NS    = 150000
) (
  input logic clk,
  input logic rst_n,
  input logic mem_zz_n,
  input logic mem_cs_n,
  input logic mem_we_n,
  input logic ready,
  input logic busy
);

  localparam int LOW_LIM = (T_ZZ_HOLD_NS + T_DPD_MIN_NS) / CLK_PERIOD_NS;

  int   low_cnt, rec_cnt;
  logic wr_seen, rec_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= 0;
      rec_cnt <= 0;
      wr_seen <= 1'b0;
      rec_on  <= 1'b0;
    end else begin
      low_cnt <= mem_zz_n ? 0 : low_cnt + 1;
      if (!mem_we_n)     wr_seen <= 1'b1;
      else if (mem_zz_n) wr_seen <= 1'b0;
      if (mem_zz_n && low_cnt != 0 && !wr_seen) begin
        rec_on  <= 1'b1;
        rec_cnt <= 1;
      end else if (rec_on) begin
        if (ready) rec_on <= 1'b0;
        else       rec_cnt <= rec_cnt + 1;
      end
    end
  end

  // R2
  cfg_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_zz_n && !mem_cs_n));

  // R2
  zz_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_zz_n));

  // R4
  post_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_cs_n && mem_zz_n));

  // R6
  cs_before_zz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_zz_n) |-> $past(mem_cs_n));

  // R10
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && busy));

  // R10
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_cs_n && mem_we_n && mem_zz_n));

  // R7
  dpd_dwell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_zz_n && low_cnt != 0 && !wr_seen) |-> (low_cnt > LOW_LIM));

  // R8
  recov_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_on |-> mem_cs_n);

  // R8
  recov_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_on && ready) |-> (rec_cnt * CLK_PERIOD_NS >= T_RECOV_NS));

endmodule

bind psram_pwr_seq psram_pwr_seq_chk #(
  .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .T_ZZ_HOLD_NS (T_ZZ_HOLD_NS),
  .T_DPD_MIN_NS (T_DPD_MIN_NS),
  .T_RECOV_NS   (T_RECOV_NS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mem_zz_n(mem_zz_n),
  .mem_cs_n(mem_cs_n),
  .mem_we_n(mem_we_n),
  .ready   (ready),
  .busy    (busy)
);

// File: tb/psram_pwr_seq_test.sv
`timescale 1ns/1ps
module psram_pwr_seq_test;

  localparam int CLK   = 4;
  localparam int PWR   = 400;
  localparam int HOLD  = 200;
  localparam int DMIN  = 2000;
  localparam int REC   = 400;
  localparam int K_CFG = 0;
  localparam int K_ZZ  = 1;
  localparam int K_RDY = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_cfg = 1'b0, req_dpd_enter = 1'b0, req_dpd_exit = 1'b0;
  logic [20:0] cfg_word = '0;
  logic busy, ready, err, mem_zz_n, mem_cs_n, mem_we_n;
  logic [20:0] mem_addr;

  always #2 clk = ~clk;

  psram_pwr_seq #(
    .CLK_PERIOD_NS(CLK), .T_PWRUP_NS(PWR), .T_ZZ_LEAD_NS(10),
    .T_WR_PULSE_NS(40), .T_GAP_NS(5), .T_ZZ_HOLD_NS(HOLD),
    .T_DPD_MIN_NS(DMIN), .T_RECOV_NS(REC)
  ) uut (.*);

  typedef struct { int kind; logic [20:0] addr; int lo; int hi; } exp_t;
  exp_t sbq[$];
  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push(input int kind, input logic [20:0] a, input int lo, input int hi);
    exp_t e;
    e.kind = kind; e.addr = a; e.lo = lo; e.hi = hi;
    sbq.push_back(e);
  endtask

  task automatic pop(input int kind, output exp_t e, output bit ok);
    ok = 1'b0;
    if (sbq.size() == 0) begin
      chk(1'b0, "R9 unexpected pin event", kind, -1);
    end else begin
      e = sbq.pop_front();
      chk(e.kind == kind, "R9 event order", kind, e.kind);
      ok = (e.kind == kind);
    end
  endtask

  int cyc = 0, zfall = 0, zrise = 0, wfall = 0, wrise = 0;
  bit pz = 1, pw = 1, pr = 0, wrote = 0, rdy_watch = 1;

  always @(negedge clk) begin
    exp_t e;
    bit ok;
    cyc++;
    if (!rst_n) begin
      pz = 1; pw = 1; pr = 0; zrise = cyc; rdy_watch = 1; wrote = 0;
    end else begin
      if (pz && !mem_zz_n) begin
        zfall = cyc; wrote = 0;
        chk(mem_cs_n == 1'b1, "R6 chip select high at sleep fall", int'(mem_cs_n), 1);
        if (wrise > 0)
          chk(cyc - wrise >= 2, "R4 gap after write", cyc - wrise, 2);
      end
      if (pw && !mem_we_n) begin
        wfall = cyc; wrote = 1;
        chk(!mem_zz_n && !mem_cs_n, "R2 strobe with sleep and select low",
            int'({mem_zz_n, mem_cs_n}), 0);
      end
      if (!pw && mem_we_n) begin
        wrise = cyc;
        chk(cyc - wfall >= 10, "R2 strobe width", cyc - wfall, 10);
        pop(K_CFG, e, ok);
        if (ok) begin
          chk(mem_addr == e.addr, "R3 config word on address", int'(mem_addr), int'(e.addr));
          chk(wfall - zfall >= e.lo && wfall - zfall <= e.hi, "R2 sleep lead",
              wfall - zfall, e.lo);
        end
      end
      if (!pz && mem_zz_n) begin
        zrise = cyc;
        if (!wrote) begin
          rdy_watch = 1;
          pop(K_ZZ, e, ok);
          if (ok) chk(cyc - zfall >= e.lo && cyc - zfall <= e.hi,
                      "R7 sleep low duration", cyc - zfall, e.lo);
        end
      end
      if (!pr && ready) begin
        if (rdy_watch) begin
          pop(K_RDY, e, ok);
          if (ok) chk(cyc - zrise >= e.lo && cyc - zrise <= e.hi,
                      "R8 ready delay", cyc - zrise, e.lo);
        end
        rdy_watch = 0;
      end
      pz = mem_zz_n; pw = mem_we_n; pr = ready;
    end
  end

  task automatic pulse(input int which, input logic [20:0] w, output bit e);
    @(negedge clk);
    cfg_word = w;
    req_cfg       = (which == 0);
    req_dpd_enter = (which == 1);
    req_dpd_exit  = (which == 2);
    @(negedge clk);
    req_cfg = 0; req_dpd_enter = 0; req_dpd_exit = 0;
    e = err;
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=1 expected=0");
    nchk++; nfail++;
    finish_run();
  end

  localparam int LOW_LO = (HOLD + DMIN) / CLK + 1;
  localparam int REC_LO = REC / CLK;
  localparam int PWR_LO = PWR / CLK;

  initial begin
    bit e;
    int hi_cnt;
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_we_n && mem_zz_n, "R1 pins inactive in reset",
        int'({mem_cs_n, mem_we_n, mem_zz_n}), 7);
    chk(!ready && busy, "R1 not ready in reset", int'({ready, busy}), 1);
    push(K_RDY, '0, PWR_LO, PWR_LO + 2);
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    chk(!ready && mem_cs_n, "R1 still waiting at mid power-up", int'(ready), 0);
    wait_ready();

    // R3: all-ones word, only bits 7..4 and 2..0 survive; bit4=1 leaves disarmed
    push(K_CFG, 21'h0000F7, 3, 125);
    pulse(0, 21'h1FFFFF, e);
    chk(!e, "R2 config accepted", int'(e), 0);
    chk(busy && !ready, "R10 busy during write", int'({busy, ready}), 2);
    wait_ready();

    // R5: disarmed enter refused
    pulse(1, '0, e);
    chk(e, "R5 enter refused when disarmed", int'(e), 1);
    hi_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_zz_n && ready) hi_cnt++;
    end
    chk(hi_cnt == 20, "R5 sleep pin stays high", hi_cnt, 20);

    // R9: exit while idle refused
    pulse(2, '0, e);
    chk(e, "R9 exit refused when idle", int'(e), 1);

    // arm with 0x65 (bit4=0); enter while busy refused
    push(K_CFG, 21'h000065, 3, 125);
    pulse(0, 21'h000065, e);
    pulse(1, '0, e);
    chk(e, "R9 enter refused while busy", int'(e), 1);
    pulse(0, 21'h000011, e);
    chk(e, "R9 config refused while busy", int'(e), 1);
    wait_ready();
    hi_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_zz_n && ready) hi_cnt++;
    end
    chk(hi_cnt == 20, "R9 refused request not queued", hi_cnt, 20);

    // R3: upper bits dropped, still armed
    push(K_CFG, 21'h0000E5, 3, 125);
    pulse(0, 21'h00ACE5, e);
    wait_ready();

    // R6/R7: enter back to back, early exit
    push(K_ZZ, '0, LOW_LO, LOW_LO + 4);
    push(K_RDY, '0, REC_LO, REC_LO + 2);
    pulse(1, '0, e);
    chk(!e, "R6 enter accepted when armed", int'(e), 0);
    repeat (8) @(negedge clk);
    chk(!mem_zz_n && mem_cs_n && busy, "R6 sleep low with select high",
        int'({mem_zz_n, mem_cs_n, busy}), 3);
    pulse(2, '0, e);
    chk(e, "R9 exit refused during hold", int'(e), 1);
    while (busy) @(negedge clk);
    chk(!ready && !mem_zz_n, "R10 powered down not ready", int'(ready), 0);
    pulse(2, '0, e);
    chk(!e, "R7 early exit accepted", int'(e), 0);
    chk(busy && !mem_zz_n, "R7 early exit held pending",
        int'({busy, mem_zz_n}), 2);
    wait_ready();

    // R11: second power down without reconfiguring, late exit
    push(K_ZZ, '0, LOW_LO, 800);
    push(K_RDY, '0, REC_LO, REC_LO + 2);
    pulse(1, '0, e);
    chk(!e, "R11 arm kept after power down", int'(e), 0);
    repeat (4) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (600) @(negedge clk);
    chk(!mem_zz_n, "R7 stays down without exit", int'(mem_zz_n), 0);
    pulse(2, '0, e);
    chk(!e, "R7 late exit accepted", int'(e), 0);
    repeat (2) @(negedge clk);
    chk(mem_zz_n && mem_cs_n && !ready, "R8 released and deselected",
        int'({mem_zz_n, mem_cs_n, ready}), 6);
    wait_ready();

    // R5: write bit4=1 to disarm
    push(K_CFG, 21'h000010, 3, 125);
    pulse(0, 21'h000010, e);
    wait_ready();
    pulse(1, '0, e);
    chk(e, "R5 enter refused after disarm", int'(e), 1);

    repeat (10) @(negedge clk);
    chk(sbq.size() == 0, "R10 all expected events seen", sbq.size(), 0);
    finish_run();
  end

endmodule